// File: doc/BRIEF.md
# Urgent Control-Frame Transmit Selector

This block picks the next frame for a transmit engine. It makes the choice only when the engine is between frames. There are two candidates. The first is a one-entry urgent descriptor slot, normally used for flow-control frames. The second is the head of the normal descriptor queue. The urgent slot has the same three fields as a queued descriptor: a 16-bit control/status word, a 16-bit length and a 32-bit buffer pointer. The slot wins whenever it holds a valid descriptor. No enable or mode setting affects this choice.

Once a frame is chosen, the block presents its length and pointer to the transmitter and waits for the transmitter to report completion. It then raises a one-cycle completion event. For an urgent frame it also writes back the slot's control word with the ready bit cleared and the error status filled in. The owner of the slot storage applies that write-back, so the same descriptor is never sent twice. The block is used between a descriptor ring manager and a frame transmitter. It fetches no data and builds no frames.

Control-word bit positions:
- bit 15: ready
- bit 12: interrupt request
- bit 11: last buffer
- bit 0: error status, set on write-back

Both the queue interface (`q_valid`/`q_ready`) and the transmitter interface (`tx_valid`/`tx_ready`) are valid/ready handshakes.
- A transfer happens on a clock edge where both valid and ready are high.
- The queue must hold its fields stable while `q_valid` is high.
- The block holds `tx_len`, `tx_ptr` and `tx_urgent` stable while `tx_valid` is high and `tx_ready` is low.

Top module: `urgent_tx_selector`

## Requirements
- R1: After reset, `tx_valid`, `evt_valid` and `slot_wb_valid` are low.
- R2: At a frame boundary, a slot whose control word has ready (bit 15) and last buffer (bit 11) both set is selected. Its length and pointer appear on `tx_len`/`tx_ptr`, and `tx_urgent` is 1.
- R3: When the slot is eligible and `q_valid` is high at the same boundary, the slot frame is issued first. `q_ready` stays low and the queued frame is not popped. The queued frame is issued at the next boundary.
- R4: When the slot is not eligible, the queued frame is popped and issued with `tx_urgent` at 0. `q_ready` is high at a boundary exactly when no eligible slot is present.
- R5: A slot with ready set but last buffer clear is ignored: nothing is issued from it, it gets no write-back, and queued frames still flow.
- R6: The slot is examined only at boundaries. A slot that becomes ready while a frame is in flight does not change that frame, and is issued at the next boundary. Slot changes after selection do not alter the issued length.
- R7: When an urgent frame completes, `slot_wb_valid` pulses for one cycle. `slot_wb_ctrl` equals the selected control word with bit 15 cleared and bit 0 equal to `tx_done_err`.
- R8: Each completed frame gives exactly one single-cycle `evt_valid` pulse, in the cycle after `tx_done`. The pulse carries the frame's interrupt flag (slot bit 12, or `q_int`) on `evt_int`, and its origin on `evt_urgent`.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_len`, `tx_ptr` and `tx_urgent` hold their values.
- R10: No frame is offered while one is in flight. `tx_done` is ignored unless a frame has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_ctrl | input | 16 | Urgent slot control/status word |
| slot_len | input | 16 | Urgent slot frame length |
| slot_ptr | input | 32 | Urgent slot buffer pointer |
| slot_wb_valid | output | 1 | Write-back strobe for the slot control word |
| slot_wb_ctrl | output | 16 | Control word to write back |
| q_valid | input | 1 | Normal queue head is valid |
| q_ready | output | 1 | Block accepts (pops) the queue head |
| q_len | input | 16 | Queue head frame length |
| q_ptr | input | 32 | Queue head buffer pointer |
| q_int | input | 1 | Queue head interrupt request |
| tx_valid | output | 1 | Frame offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts the frame |
| tx_len | output | 16 | Offered frame length |
| tx_ptr | output | 32 | Offered buffer pointer |
| tx_urgent | output | 1 | Offered frame comes from the urgent slot |
| tx_done | input | 1 | Transmitter finished the accepted frame |
| tx_done_err | input | 1 | Error status for the finished frame |
| evt_valid | output | 1 | One-cycle completion event |
| evt_int | output | 1 | Interrupt request of the completed frame |
| evt_urgent | output | 1 | Completed frame came from the slot |

## Verification
The bench builds the block with its default widths: 16-bit length and 32-bit pointer. These widths let every pointer bit and a full-range length be checked on the transmit side. The bench keeps a model of the slot register that applies the write-back. This brings the ready-clear loop within reach: it shows that an urgent frame is sent once and only once. Back-pressure is held for several cycles while the slot contents change underneath. This brings into reach the rule that the length latched at selection is the one that is offered.

// File: rtl/uts_pkg.sv
package uts_pkg;
  localparam int CTRL_W   = 16;
  localparam int RDY_BIT  = 15;
  localparam int INT_BIT  = 12;
  localparam int LAST_BIT = 11;
  localparam int ERR_BIT  = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_BUSY  = 2'd2,
    ST_DONE  = 2'd3
  } sel_state_e;
endpackage

// File: rtl/uts_slot_decode.sv
module uts_slot_decode
  import uts_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output logic              eligible,
  output logic              int_flag
);
  // A slot is usable only as a complete single-buffer frame.
  assign eligible = ctrl[RDY_BIT] & ctrl[LAST_BIT];
  assign int_flag = ctrl[INT_BIT];
endmodule

// File: rtl/uts_frame_sel.sv
module uts_frame_sel
  import uts_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_elig,
  input  logic              slot_int,
  input  logic [CTRL_W-1:0] slot_ctrl,
  input  logic [LEN_W-1:0]  slot_len,
  input  logic [PTR_W-1:0]  slot_ptr,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [LEN_W-1:0]  q_len,
  input  logic [PTR_W-1:0]  q_ptr,
  input  logic              q_int,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [LEN_W-1:0]  tx_len,
  output logic [PTR_W-1:0]  tx_ptr,
  output logic              tx_urgent,
  input  logic              tx_done,
  output logic              done_hit,
  output logic              cur_int,
  output logic [CTRL_W-1:0] cur_ctrl
);
  sel_state_e        state;
  logic [LEN_W-1:0]  lat_len;
  logic [PTR_W-1:0]  lat_ptr;
  logic              lat_urg;
  logic              lat_int;
  logic [CTRL_W-1:0] lat_ctrl;
  logic              at_boundary;
  logic              pick_slot;
  logic              pick_q;

  assign at_boundary = (state == ST_IDLE);
  assign pick_slot   = at_boundary & slot_elig;
  assign q_ready     = at_boundary & ~slot_elig;
  assign pick_q      = q_ready & q_valid;
  assign done_hit    = (state == ST_BUSY) & tx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lat_len  <= '0;
      lat_ptr  <= '0;
      lat_urg  <= 1'b0;
      lat_int  <= 1'b0;
      lat_ctrl <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pick_slot) begin
            lat_len  <= slot_len;
            lat_ptr  <= slot_ptr;
            lat_urg  <= 1'b1;
            lat_int  <= slot_int;
            lat_ctrl <= slot_ctrl;
            state    <= ST_ISSUE;
          end else if (pick_q) begin
            lat_len  <= q_len;
            lat_ptr  <= q_ptr;
            lat_urg  <= 1'b0;
            lat_int  <= q_int;
            lat_ctrl <= '0;
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (tx_ready) state <= ST_BUSY;
        ST_BUSY:  if (tx_done)  state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid  = (state == ST_ISSUE);
  assign tx_len    = lat_len;
  assign tx_ptr    = lat_ptr;
  assign tx_urgent = lat_urg;
  assign cur_int   = lat_int;
  assign cur_ctrl  = lat_ctrl;

  a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_len) && $stable(tx_ptr) && $stable(tx_urgent)));

  a_r4_pop_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready) |=> (tx_valid && !tx_urgent));

  a_r2_slot_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && slot_elig) |=> (tx_valid && tx_urgent));
endmodule

// File: rtl/uts_complete.sv
module uts_complete
  import uts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_hit,
  input  logic              cur_urgent,
  input  logic              cur_int,
  input  logic [CTRL_W-1:0] cur_ctrl,
  input  logic              done_err,
  output logic              evt_valid,
  output logic              evt_int,
  output logic              evt_urgent,
  output logic              wb_valid,
  output logic [CTRL_W-1:0] wb_ctrl
);
  logic [CTRL_W-1:0] next_ctrl;

  always_comb begin
    next_ctrl          = cur_ctrl;
    next_ctrl[RDY_BIT] = 1'b0;
    next_ctrl[ERR_BIT] = done_err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid  <= 1'b0;
      evt_int    <= 1'b0;
      evt_urgent <= 1'b0;
      wb_valid   <= 1'b0;
      wb_ctrl    <= '0;
    end else begin
      evt_valid <= done_hit;
      wb_valid  <= done_hit & cur_urgent;
      if (done_hit) begin
        evt_int    <= cur_int;
        evt_urgent <= cur_urgent;
        wb_ctrl    <= next_ctrl;
      end
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  a_r7_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !wb_ctrl[RDY_BIT]);

  a_r7_wb_urgent_only: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (evt_valid && evt_urgent));
endmodule

// File: rtl/urgent_tx_selector.sv
module urgent_tx_selector
  import uts_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] slot_ctrl,
  input  logic [LEN_W-1:0]  slot_len,
  input  logic [PTR_W-1:0]  slot_ptr,
  output logic              slot_wb_valid,
  output logic [CTRL_W-1:0] slot_wb_ctrl,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [LEN_W-1:0]  q_len,
  input  logic [PTR_W-1:0]  q_ptr,
  input  logic              q_int,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [LEN_W-1:0]  tx_len,
  output logic [PTR_W-1:0]  tx_ptr,
  output logic              tx_urgent,
  input  logic              tx_done,
  input  logic              tx_done_err,
  output logic              evt_valid,
  output logic              evt_int,
  output logic              evt_urgent
);
  logic              slot_elig;
  logic              slot_int;
  logic              done_hit;
  logic              cur_int;
  logic [CTRL_W-1:0] cur_ctrl;

  uts_slot_decode u_dec (
    .ctrl     (slot_ctrl),
    .eligible (slot_elig),
    .int_flag (slot_int)
  );

  uts_frame_sel #(.LEN_W(LEN_W), .PTR_W(PTR_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_elig (slot_elig),
    .slot_int  (slot_int),
    .slot_ctrl (slot_ctrl),
    .slot_len  (slot_len),
    .slot_ptr  (slot_ptr),
    .q_valid   (q_valid),
    .q_ready   (q_ready),
    .q_len     (q_len),
    .q_ptr     (q_ptr),
    .q_int     (q_int),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_len    (tx_len),
    .tx_ptr    (tx_ptr),
    .tx_urgent (tx_urgent),
    .tx_done   (tx_done),
    .done_hit  (done_hit),
    .cur_int   (cur_int),
    .cur_ctrl  (cur_ctrl)
  );

  uts_complete u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_hit   (done_hit),
    .cur_urgent (tx_urgent),
    .cur_int    (cur_int),
    .cur_ctrl   (cur_ctrl),
    .done_err   (tx_done_err),
    .evt_valid  (evt_valid),
    .evt_int    (evt_int),
    .evt_urgent (evt_urgent),
    .wb_valid   (slot_wb_valid),
    .wb_ctrl    (slot_wb_ctrl)
  );

  // R3: the queue is never popped while the decoder reports an eligible slot
  a_r3_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready |-> !slot_elig);

  // R10: no offer while the completion event is being reported
  a_r10_no_offer_at_evt: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !tx_valid);
endmodule

// File: tb/urgent_tx_selector_test.sv
module urgent_tx_selector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] slot_ctrl = '0;
  logic [15:0] slot_len = '0;
  logic [31:0] slot_ptr = '0;
  logic        slot_wb_valid;
  logic [15:0] slot_wb_ctrl;
  logic        q_valid = 1'b0;
  logic        q_ready;
  logic [15:0] q_len = '0;
  logic [31:0] q_ptr = '0;
  logic        q_int = 1'b0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [15:0] tx_len;
  logic [31:0] tx_ptr;
  logic        tx_urgent;
  logic        tx_done = 1'b0;
  logic        tx_done_err = 1'b0;
  logic        evt_valid;
  logic        evt_int;
  logic        evt_urgent;

  int checks = 0;
  int errors = 0;
  int pops = 0;
  bit finished = 0;

  localparam logic [15:0] RDY  = 16'h8000;
  localparam logic [15:0] INTR = 16'h1000;
  localparam logic [15:0] LAST = 16'h0800;

  always #4 clk = ~clk;

  urgent_tx_selector uut (
    .clk(clk), .rst_n(rst_n),
    .slot_ctrl(slot_ctrl), .slot_len(slot_len), .slot_ptr(slot_ptr),
    .slot_wb_valid(slot_wb_valid), .slot_wb_ctrl(slot_wb_ctrl),
    .q_valid(q_valid), .q_ready(q_ready), .q_len(q_len), .q_ptr(q_ptr), .q_int(q_int),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_len(tx_len), .tx_ptr(tx_ptr),
    .tx_urgent(tx_urgent), .tx_done(tx_done), .tx_done_err(tx_done_err),
    .evt_valid(evt_valid), .evt_int(evt_int), .evt_urgent(evt_urgent)
  );

  // Slot storage owner: applies the write-back
  always @(posedge clk) if (slot_wb_valid) slot_ctrl <= slot_wb_ctrl;
  // Queue pop monitor
  always @(posedge clk) if (rst_n && q_valid && q_ready) pops <= pops + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_issue(input bit urg, input logic [15:0] len, input logic [31:0] ptr, input string tag);
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (tx_valid) seen = 1;
    end
    chk(seen, {tag, " offer"}, {31'd0, seen}, 32'd1);
    chk(tx_urgent == urg, {tag, " origin"}, {31'd0, tx_urgent}, {31'd0, urg});
    chk(tx_len == len, {tag, " length"}, {16'd0, tx_len}, {16'd0, len});
    chk(tx_ptr == ptr, {tag, " pointer"}, tx_ptr, ptr);
  endtask

  task automatic accept(input int hold);
    logic [15:0] l0 = tx_len;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_len == l0, "R9 hold under back-pressure", {15'd0, tx_valid, tx_len}, {15'd0, 1'b1, l0});
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk(!tx_valid, "R10 offer dropped after accept", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic finish_frame(input bit err, input bit urg, input bit irq, input logic [15:0] wb_exp, input string tag);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!tx_valid && !evt_valid, "R10 quiet while in flight", {30'd0, tx_valid, evt_valid}, 32'd0);
    end
    tx_done = 1'b1; tx_done_err = err;
    @(negedge clk);
    tx_done = 1'b0; tx_done_err = 1'b0;
    chk(evt_valid, {tag, " R8 event"}, {31'd0, evt_valid}, 32'd1);
    chk(evt_urgent == urg, {tag, " R8 event origin"}, {31'd0, evt_urgent}, {31'd0, urg});
    chk(evt_int == irq, {tag, " R8 event int"}, {31'd0, evt_int}, {31'd0, irq});
    chk(slot_wb_valid == urg, {tag, " R7 writeback strobe"}, {31'd0, slot_wb_valid}, {31'd0, urg});
    if (urg) chk(slot_wb_ctrl == wb_exp, {tag, " R7 writeback word"}, {16'd0, slot_wb_ctrl}, {16'd0, wb_exp});
    @(negedge clk);
    chk(!evt_valid && !slot_wb_valid, "R8 single-cycle event", {30'd0, evt_valid, slot_wb_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk(!tx_valid && !evt_valid && !slot_wb_valid, "R1 reset outputs", {29'd0, tx_valid, evt_valid, slot_wb_valid}, 32'd0);
    chk(q_ready, "R4 q_ready with empty slot", {31'd0, q_ready}, 32'd1);
  endtask

  task automatic t_normal();
    int p0 = pops;
    q_len = 16'd100; q_ptr = 32'h0000_1000; q_int = 1'b1; q_valid = 1'b1;
    expect_issue(1'b0, 16'd100, 32'h0000_1000, "R4 normal");
    q_valid = 1'b0;
    chk(pops == p0 + 1, "R4 single pop", pops, p0 + 1);
    accept(0);
    finish_frame(1'b0, 1'b0, 1'b1, 16'h0, "R4");
  endtask

  task automatic t_urgent();
    slot_len = 16'd64; slot_ptr = 32'hA5A5_2000; slot_ctrl = RDY | LAST | INTR | 16'h0040;
    expect_issue(1'b1, 16'd64, 32'hA5A5_2000, "R2 urgent");
    accept(0);
    finish_frame(1'b1, 1'b1, 1'b1, 16'h1841, "R2");
    chk(slot_ctrl[15] == 1'b0, "R7 slot ready cleared", {16'd0, slot_ctrl}, 32'h1841);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(!tx_valid, "R7 slot not resent", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_both();
    int p0 = pops;
    q_len = 16'd200; q_ptr = 32'h0000_3000; q_int = 1'b0; q_valid = 1'b1;
    slot_len = 16'd60; slot_ptr = 32'h0000_4000; slot_ctrl = RDY | LAST;
    expect_issue(1'b1, 16'd60, 32'h0000_4000, "R3 slot first");
    chk(!q_ready && pops == p0, "R3 queue not popped", pops, p0);
    accept(0);
    finish_frame(1'b0, 1'b1, 1'b0, 16'h0800, "R3");
    expect_issue(1'b0, 16'd200, 32'h0000_3000, "R3 queued follows");
    q_valid = 1'b0;
    accept(0);
    finish_frame(1'b0, 1'b0, 1'b0, 16'h0, "R3");
  endtask

  task automatic t_no_last();
    slot_len = 16'd70; slot_ptr = 32'h0000_5000; slot_ctrl = RDY | INTR;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!tx_valid && !slot_wb_valid, "R5 slot without last ignored", {30'd0, tx_valid, slot_wb_valid}, 32'd0);
    end
    q_len = 16'd300; q_ptr = 32'h0000_6000; q_int = 1'b0; q_valid = 1'b1;
    expect_issue(1'b0, 16'd300, 32'h0000_6000, "R5 queue flows");
    q_valid = 1'b0;
    accept(0);
    finish_frame(1'b0, 1'b0, 1'b0, 16'h0, "R5");
    chk(slot_ctrl == (RDY | INTR), "R5 slot untouched", {16'd0, slot_ctrl}, {16'd0, RDY | INTR});
    slot_ctrl = 16'h0;
  endtask

  task automatic t_midframe();
    q_len = 16'd400; q_ptr = 32'h0000_7000; q_int = 1'b1; q_valid = 1'b1;
    expect_issue(1'b0, 16'd400, 32'h0000_7000, "R6 normal in flight");
    q_valid = 1'b0;
    accept(0);
    slot_len = 16'd90; slot_ptr = 32'h0000_8000; slot_ctrl = RDY | LAST;
    finish_frame(1'b0, 1'b0, 1'b1, 16'h0, "R6 normal");
    expect_issue(1'b1, 16'd90, 32'h0000_8000, "R6 slot next boundary");
    accept(0);
    finish_frame(1'b0, 1'b1, 1'b0, 16'h0800, "R6 slot");
  endtask

  task automatic t_backpressure();
    slot_len = 16'hFFFF; slot_ptr = 32'hFFFF_FFFC; slot_ctrl = RDY | LAST | INTR;
    expect_issue(1'b1, 16'hFFFF, 32'hFFFF_FFFC, "R9 offer");
    slot_len = 16'd1;
    // R10: a stray done before acceptance has no effect
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk(!evt_valid && tx_valid, "R10 stray done ignored", {30'd0, evt_valid, tx_valid}, 32'd1);
    accept(4);
    chk(tx_len == 16'hFFFF, "R6 latched length kept", {16'd0, tx_len}, 32'hFFFF);
    finish_frame(1'b0, 1'b1, 1'b1, 16'h1800, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_urgent();
    t_both();
    t_no_last();
    t_midframe();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule